// File: doc/BRIEF.md
# Interval Tick Timer

This block is a periodic timer that sits on a plain 32-bit register bus. A 20-bit phase counter steps once per clock while the timer runs. It returns to zero after it reaches a programmed limit. Each return adds one to a 12-bit lap counter and raises a pending flag. When the interrupt is enabled, the pending flag drives the interrupt pin.

Software learns the exact elapsed time by reading a single word that packs the lap count above the phase count. Two word-select locations return this word. One is an acknowledging snapshot: it returns the live value and, on the same clock edge, clears the lap count and the pending flag. A lap that ends on that same edge is kept as a count of one, and the flag stays raised. The other is a passive snapshot that changes nothing. Because the lap count keeps accumulating, software that services the interrupt late still knows how many periods it missed.

The asynchronous active-low reset enters through a two-stage synchronizer, so it is released in step with the clock.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset, all four locations read as zero and `irq` is low.
- R2: A write to offset 0x0 sets three fields: the phase limit from bits 19:0, the run bit from bit 24 and the interrupt-enable bit from bit 25. Reading offset 0x0 returns these three fields in the same positions, with every other bit zero.
- R3: While the run bit is set, the phase counter goes up by one on each clock. On the clock after it equals the limit, it returns to 0, the lap count goes up by one, and bit 0 of offset 0x4 (the pending flag) is set.
- R4: Offset 0x8 returns the lap count in bits 31:20 and the phase in bits 19:0, as they stand before the edge. On that edge the lap count becomes 0 and the pending flag is cleared. If a lap also ends on that edge, the lap count becomes 1 and the flag stays set.
- R5: Offset 0xC returns the same layout as offset 0x8 and changes no state.
- R6: The lap count wraps from 4095 to 0.
- R7: `irq` equals the pending flag ANDed with the interrupt-enable bit.
- R8: While the run bit is clear, the phase counter, the lap count and the pending flag are all held at zero. Writing 0 to offset 0x0 stops counting and masks the interrupt. Setting the run bit again starts counting from zero.
- R9: The number of running clocks since the run bit was set or since the last acknowledge equals lap × (limit + 1) + phase.
- R10: Reading offset 0x4 does not clear the flag. Writes to offsets 0x4, 0x8 and 0xC have no effect.
- R11: If the limit is lowered below the current phase, the phase returns to 0 on the next clock and counts one lap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte address; bits 3:2 select the location |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; the acknowledge takes effect on the edge that ends the read cycle |
| bus_rdata | output | 32 | Read data, valid combinationally during `bus_rd`, zero otherwise |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default widths: a 20-bit phase, a 12-bit lap count and a 4-bit address. Limits of 0 to 9 keep every phase return within a few clocks of the stimulus. A limit of 0 returns the phase on every clock. This drives the lap count through its full 4096-value wrap in about four thousand cycles. Short limits also make it cheap to line up an acknowledging read with the exact edge on which a lap ends, and to lower the limit below a live phase.

// File: rtl/itt_pkg.sv
package itt_pkg;
  localparam int unsigned CUR_W   = 20;
  localparam int unsigned OVF_W   = 12;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned RUN_BIT = 24;
  localparam int unsigned IEN_BIT = 25;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    SEL_MODE      = 2'd0,
    SEL_FLAG      = 2'd1,
    SEL_SNAP_ACK  = 2'd2,
    SEL_SNAP_PEEK = 2'd3
  } sel_e;

  typedef struct packed {
    logic             irq_en;
    logic             run;
    logic [CUR_W-1:0] period;
  } mode_t;
endpackage

// File: rtl/itt_rst_sync.sv
module itt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/itt_mode_reg.sv
module itt_mode_reg
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output mode_t             mode,
  output sel_e              sel,
  output logic              rd_hit,
  output logic              ack_rd
);
  logic  hi_zero;
  logic  mode_we;
  mode_t mode_q;
  mode_t mode_d;

  generate
    if (ADDR_W > WORD_LSB + 2) begin : g_hi
      assign hi_zero = (bus_addr[ADDR_W-1:WORD_LSB+2] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign sel    = sel_e'(bus_addr[WORD_LSB +: 2]);
  assign rd_hit = bus_rd && hi_zero;
  assign ack_rd = rd_hit && (sel == SEL_SNAP_ACK);

  always_comb begin
    mode_we = bus_wr && hi_zero && (sel == SEL_MODE);
    mode_d  = mode_q;
    if (mode_we) begin
      mode_d.period = bus_wdata[CUR_W-1:0];
      mode_d.run    = bus_wdata[RUN_BIT];
      mode_d.irq_en = bus_wdata[IEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R2 / R10: only a write to the mode location moves the mode fields
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hi_zero && bus_addr[WORD_LSB +: 2] == 2'd0) |=> $stable(mode_q));
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hi_zero && bus_addr[WORD_LSB +: 2] == 2'd0)
      |=> mode_q.run == $past(bus_wdata[RUN_BIT]));
endmodule

// File: rtl/itt_counter.sv
module itt_counter
  import itt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CUR_W-1:0] period,
  input  logic             ack,
  output logic [CUR_W-1:0] cur,
  output logic [OVF_W-1:0] ovf,
  output logic             flag
);
  logic [CUR_W-1:0] cur_q, cur_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             flag_q, flag_d;
  logic             wrap;
  logic             cnt_en;

  assign wrap   = run && (cur_q >= period);
  assign cnt_en = run || (cur_q != '0) || (ovf_q != '0) || flag_q;

  always_comb begin
    cur_d  = '0;
    ovf_d  = '0;
    flag_d = 1'b0;
    if (run) begin
      cur_d = wrap ? '0 : cur_q + 1'b1;
      if (ack) begin
        ovf_d  = wrap ? OVF_W'(1) : '0;
        flag_d = wrap;
      end else begin
        ovf_d  = wrap ? ovf_q + 1'b1 : ovf_q;
        flag_d = flag_q | wrap;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      ovf_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_en) begin
      cur_q  <= cur_d;
      ovf_q  <= ovf_d;
      flag_q <= flag_d;
    end
  end

  assign cur  = cur_q;
  assign ovf  = ovf_q;
  assign flag = flag_q;

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_q < period) |=> cur_q == CUR_W'($past(cur_q) + 1'b1));
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_q >= period) |=> (cur_q == '0) && flag_q);
  a_r4_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && run && cur_q < period) |=> (ovf_q == '0) && !flag_q);
  a_r4_ack_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && run && cur_q >= period) |=> (ovf_q == OVF_W'(1)) && flag_q);
  a_r6_lap_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_q >= period && !ack && ovf_q == '1) |=> ovf_q == '0);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cur_q == '0) && (ovf_q == '0) && !flag_q);
endmodule

// File: rtl/itt_read_mux.sv
module itt_read_mux
  import itt_pkg::*;
(
  input  logic              rd_hit,
  input  sel_e              sel,
  input  mode_t             mode,
  input  logic [CUR_W-1:0]  cur,
  input  logic [OVF_W-1:0]  ovf,
  input  logic              flag,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned SNAP_W = CUR_W + OVF_W;
  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_MODE: begin
        word[CUR_W-1:0] = mode.period;
        word[RUN_BIT]   = mode.run;
        word[IEN_BIT]   = mode.irq_en;
      end
      SEL_FLAG:      word[0] = flag;
      SEL_SNAP_ACK,
      SEL_SNAP_PEEK: word[SNAP_W-1:0] = {ovf, cur};
      default:       word = '0;
    endcase
  end

  assign rdata = rd_hit ? word : '0;
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic             rst_n_s;
  mode_t            mode;
  sel_e             sel;
  logic             rd_hit;
  logic             ack_rd;
  logic [CUR_W-1:0] cur;
  logic [OVF_W-1:0] ovf;
  logic             flag;

  itt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  itt_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .mode      (mode),
    .sel       (sel),
    .rd_hit    (rd_hit),
    .ack_rd    (ack_rd)
  );

  itt_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (mode.run),
    .period (mode.period),
    .ack    (ack_rd),
    .cur    (cur),
    .ovf    (ovf),
    .flag   (flag)
  );

  itt_read_mux u_rmux (
    .rd_hit (rd_hit),
    .sel    (sel),
    .mode   (mode),
    .cur    (cur),
    .ovf    (ovf),
    .flag   (flag),
    .rdata  (bus_rdata)
  );

  assign irq = flag & mode.irq_en;

  // R7: the pin rises only when the pending flag was set by a lap end or the mask was lifted
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> flag && mode.irq_en);
  a_r7_masked_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mode.irq_en |-> !irq);
endmodule

// File: tb/test_interval_tick_timer.sv
module test_interval_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  // reference model state
  int m_cur = 0, m_cnt = 0, m_per = 0;
  bit m_stat = 0, m_en = 0, m_ien = 0;

  always #5 clk = ~clk;

  interval_tick_timer i_interval_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(logic [3:0] a);
    case (a[3:2])
      2'd0: return (m_per & 32'hFFFFF) | (32'(m_en) << 24) | (32'(m_ien) << 25);
      2'd1: return 32'(m_stat);
      default: return (32'(m_cnt) << 20) | 32'(m_cur);
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    bit w, ack, ns;
    int nc, nn;
    if (!rst_n) begin
      m_cur = 0; m_cnt = 0; m_per = 0; m_stat = 0; m_en = 0; m_ien = 0;
    end else begin
      w   = m_en && (m_cur >= m_per);
      ack = rd && (addr == 4'h8);
      if (!m_en) begin
        nc = 0; nn = 0; ns = 0;
      end else begin
        nc = w ? 0 : m_cur + 1;
        if (ack) begin nn = w ? 1 : 0; ns = w; end
        else begin nn = w ? (m_cnt + 1) % 4096 : m_cnt; ns = m_stat | w; end
      end
      if (wr && addr == 4'h0) begin
        m_per = int'(wdata[19:0]); m_en = wdata[24]; m_ien = wdata[25];
      end
      m_cur = nc; m_cnt = nn; m_stat = ns;
    end
  end

  // every-clock comparison against the model (R3, R7, R9)
  always @(negedge clk) begin
    if (live) begin
      chk("R7 irq vs model", {31'b0, irq}, {31'b0, m_stat & m_ien});
      chk("R3 rdata vs model", rdata, rd ? model_word(addr) : 32'h0);
    end
  end

  task automatic wr_op(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #1;
    rd = 1'b0; wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    wr = 1'b0; rd = 1'b1; addr = a;
    #3;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rd = 1'b0; wr = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    live = 1'b1;
    // R1 reset state
    rd_chk(4'h0, 32'h0, "R1 mode after reset");
    rd_chk(4'h4, 32'h0, "R1 flag after reset");
    rd_chk(4'hC, 32'h0, "R1 peek after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    // R2 mode load with stray bits, limit 4, run, irq masked
    wr_op(4'h0, 32'hC1F0_0004);
    rd_chk(4'h0, 32'h0100_0004, "R2 mode readback");
    idle(10);
    rd_chk(4'hC, 32'h0020_0001, "R9 laps*5+phase after 11 clocks");
    rd_chk(4'h4, 32'h1, "R3 flag set by lap end");
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    // R4 acknowledge
    rd_chk(4'h8, 32'h0020_0003, "R4 ack returns pre-clear value");
    rd_chk(4'h8, 32'h0000_0004, "R4 ack sees cleared count");
    rd_chk(4'h4, 32'h1, "R4 flag kept when lap ends on ack edge");
    rd_chk(4'hC, 32'h0010_0001, "R4 count is one after same-edge lap");
    rd_chk(4'hC, 32'h0010_0002, "R5 peek does not clear");
    // R7 unmask
    wr_op(4'h0, 32'h0300_0004);
    rd_chk(4'h4, 32'h1, "R10 flag read keeps flag");
    chk("R7 irq when unmasked", {31'b0, irq}, 32'h1);
    // R10 writes elsewhere ignored
    wr_op(4'h4, 32'hFFFF_FFFF);
    wr_op(4'h8, 32'hFFFF_FFFF);
    wr_op(4'hC, 32'hFFFF_FFFF);
    rd_chk(4'hC, 32'h0020_0003, "R10 counters untouched by writes");
    rd_chk(4'h0, 32'h0300_0004, "R10 mode untouched by writes");
    // R8 stop and restart
    wr_op(4'h0, 32'h0);
    idle(1);
    rd_chk(4'hC, 32'h0, "R8 counters cleared when stopped");
    rd_chk(4'h4, 32'h0, "R8 flag cleared when stopped");
    chk("R8 irq low when stopped", {31'b0, irq}, 32'h0);
    wr_op(4'h0, 32'h0100_0002);
    rd_chk(4'hC, 32'h0, "R8 restart from zero");
    // R11 lowered limit
    wr_op(4'h0, 32'h0);
    idle(1);
    wr_op(4'h0, 32'h0100_0009);
    idle(7);
    wr_op(4'h0, 32'h0100_0003);
    rd_chk(4'hC, 32'h0000_0008, "R11 phase above new limit");
    rd_chk(4'hC, 32'h0010_0000, "R11 wraps on next clock");
    // R6 lap count wrap with limit 0
    wr_op(4'h0, 32'h0);
    idle(1);
    wr_op(4'h0, 32'h0100_0000);
    idle(4099);
    rd_chk(4'hC, 32'h0030_0000, "R6 lap count modulo 4096");
    idle(2);
    finish_run();
  end
endmodule